// File: doc/BRIEF.md
# Transmit Mode Control Register

This block is the host-visible transmit mode register of a 10 Mb/s Ethernet controller, together with the small control logic it drives. The host writes three mode bits and reads back a live collision tally for the frame being sent. The same register word also shows a chip-test bit that the host can never set.

From the mode bits the block derives four things. It produces the DMA request line for a DMA sequencer that reports the cycles left in a burst. It produces the loopback enable and the line-output enable for the encoder path. It also produces a flag that tells the transmitter to ignore carrier sense.

The collision tally counts collision strobes from the MAC. It saturates at its maximum and returns to zero when the MAC signals that the frame is finished. In standard loopback mode, a collision that arrives while the link has failed or the jabber guard has tripped drops loopback for the rest of that frame, so that receive data from the line is accepted.

Top module: `txmode_reg`

## Requirements
- R1: After reset the register reads 0x06: tally 0 in bits 7..4, test bit 3 = 0, DREQ-early bit 2 = 1, loopback-mode bit 1 = 1, carrier-ignore bit 0 = 0. DREQ is low and carrierIgnore is low.
- R2: A host write updates only bits 2..0. Bits 7..4 keep the tally, and bit 3 always reads 0, even after a write of 1.
- R3: Each cycle with colStrobe high adds one to the tally in bits 7..4. The tally stops at 15 and does not wrap.
- R4: A cycle with txDoneStrobe high makes the tally 0 in the next cycle, even if colStrobe is high in the same cycle.
- R5: With bit 2 = 0, dmaStart arms DREQ from the next cycle. DREQ is low, in the same cycle, whenever dmaRemain is 0. Once DREQ has dropped, it stays low until the next dmaStart.
- R6: With bit 2 = 1, DREQ drops in the same cycle in which dmaRemain is 2 or less. It stays low until the next dmaStart.
- R7: With bit 1 = 0, loopbackEn is 1 and lineTxEn is 0. This holds whatever the collision, link-fail, jabber or transmit-active state.
- R8: With bit 1 = 1, lineTxEn is 1. loopbackEn is 1 only while txActive is 1 and the frame's loopback has not been cancelled.
- R9: With bit 1 = 1, a collision strobe seen while linkFail or jabber is high cancels loopback from the next cycle. The cancel lasts until the next txDoneStrobe.
- R10: carrierIgnore follows bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Host write strobe |
| regWrData | input | 8 | Host write data |
| regRdData | output | 8 | Register read value |
| colStrobe | input | 1 | One-cycle collision pulse from the MAC |
| txDoneStrobe | input | 1 | One-cycle frame-complete pulse from the MAC |
| txActive | input | 1 | High while a frame is being sent |
| linkFail | input | 1 | Link-integrity failure status |
| jabber | input | 1 | Jabber guard status |
| dmaStart | input | 1 | Start of a new DMA transfer |
| dmaRemain | input | 8 | Cycles left in the current DMA transfer |
| dreq | output | 1 | DMA request |
| loopbackEn | output | 1 | Loop transmit data back to the receiver |
| lineTxEn | output | 1 | Pass transmit data to the line output |
| carrierIgnore | output | 1 | Send regardless of carrier sense |

## Verification
The assertions check on every cycle the rules that hold whatever the history. DREQ is low whenever dmaRemain is at or below the active threshold. Forced loopback always blocks the line output. Standard loopback is off when no frame is being sent. The tally is zero after a frame-done strobe and never wraps from 15. A cancelling collision turns loopback off in the next cycle. The bench scenarios cover the sequences a single-cycle property cannot: the reset value, ignored write bits read back through the register, the exact count of a run of collisions, DREQ staying low after it drops until a new start, and loopback coming back after the frame that cancelled it ends.

// File: rtl/txmode_pkg.sv
package txmode_pkg;

  // Bit positions of the mode field; the host decodes these
  localparam int unsigned CARRIER_BIT = 0;
  localparam int unsigned LOOPMODE_BIT = 1;
  localparam int unsigned DREQEARLY_BIT = 2;
  localparam int unsigned TEST_BIT = 3;
  localparam int unsigned MODE_W = 3;

  // Mode value after reset: early DREQ, standard loopback, carrier honoured
  localparam logic [MODE_W-1:0] MODE_RESET = 3'b110;

  // Strobes passed from the control module to the datapath
  typedef struct packed {
    logic wrMode;
    logic incCol;
    logic clrCol;
    logic setCancel;
    logic clrCancel;
    logic armDreq;
    logic disarmDreq;
  } txCtlStrobes_t;

endpackage

// File: rtl/txmode_ctrl.sv
module txmode_ctrl
  import txmode_pkg::*;
#(
  parameter int unsigned REM_W = 8,
  parameter int unsigned EARLY_GAP = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             regWrEn,
  input  logic             colStrobe,
  input  logic             txDoneStrobe,
  input  logic             linkFail,
  input  logic             jabber,
  input  logic             dmaStart,
  input  logic [REM_W-1:0] dmaRemain,
  input  logic             dreqEarly,
  input  logic             loopMode,
  input  logic             dreqArmed,
  output logic             dreqReached,
  output txCtlStrobes_t    strobes
);

  localparam logic [REM_W-1:0] GAP_CYC = REM_W'(EARLY_GAP);

  logic [REM_W-1:0] dropThreshold;
  logic             cancelCause;

  // Early mode moves the drop point EARLY_GAP cycles ahead of the last one
  always_comb begin
    dropThreshold = dreqEarly ? GAP_CYC : '0;
    dreqReached = (dmaRemain <= dropThreshold);
  end

  assign cancelCause = colStrobe && (linkFail || jabber) && loopMode;

  always_comb begin
    strobes = '0;
    strobes.wrMode = regWrEn;
    // Frame end wins over a collision arriving in the same cycle
    strobes.clrCol = txDoneStrobe;
    strobes.incCol = colStrobe && !txDoneStrobe;
    strobes.clrCancel = txDoneStrobe;
    strobes.setCancel = cancelCause && !txDoneStrobe;
    // A new transfer wins over the drop of the previous one
    strobes.armDreq = dmaStart;
    strobes.disarmDreq = dreqArmed && dreqReached && !dmaStart;
  end

  // R4: a frame end never counts as a collision
  p_clear_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    txDoneStrobe |-> !strobes.incCol);

  // R5/R6: arming and disarming never both fire
  p_arm_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(strobes.armDreq && strobes.disarmDreq));

endmodule

// File: rtl/txmode_datapath.sv
module txmode_datapath
  import txmode_pkg::*;
#(
  parameter int unsigned COL_W = 4,
  parameter int unsigned REG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  txCtlStrobes_t    strobes,
  input  logic [REG_W-1:0] regWrData,
  input  logic             txActive,
  input  logic             dreqReached,
  output logic [REG_W-1:0] regRdData,
  output logic             dreq,
  output logic             dreqArmed,
  output logic             dreqEarly,
  output logic             loopMode,
  output logic             loopbackEn,
  output logic             lineTxEn,
  output logic             carrierIgnore
);

  localparam logic [COL_W-1:0] COL_MAX = '1;
  localparam int unsigned COL_LSB = TEST_BIT + 1;

  logic [MODE_W-1:0] modeBits;
  logic [COL_W-1:0]  colCnt;
  logic              cancelStd;

  // Mode bits: only the writable field follows host data
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      modeBits <= MODE_RESET;
    end else if (strobes.wrMode) begin
      modeBits <= regWrData[MODE_W-1:0];
    end
  end

  // Collision tally, saturating, cleared at frame end
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      colCnt <= '0;
    end else if (strobes.clrCol) begin
      colCnt <= '0;
    end else if (strobes.incCol && (colCnt != COL_MAX)) begin
      colCnt <= colCnt + 1'b1;
    end
  end

  // Standard-loopback cancel flag for the current frame
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cancelStd <= 1'b0;
    end else if (strobes.clrCancel) begin
      cancelStd <= 1'b0;
    end else if (strobes.setCancel) begin
      cancelStd <= 1'b1;
    end
  end

  // DMA request arm flag
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dreqArmed <= 1'b0;
    end else if (strobes.armDreq) begin
      dreqArmed <= 1'b1;
    end else if (strobes.disarmDreq) begin
      dreqArmed <= 1'b0;
    end
  end

  always_comb begin
    carrierIgnore = modeBits[CARRIER_BIT];
    loopMode = modeBits[LOOPMODE_BIT];
    dreqEarly = modeBits[DREQEARLY_BIT];
    dreq = dreqArmed && !dreqReached;
    if (!loopMode) begin
      loopbackEn = 1'b1;
      lineTxEn = 1'b0;
    end else begin
      loopbackEn = txActive && !cancelStd;
      lineTxEn = 1'b1;
    end
  end

  // Register image: tally above the test bit, which always reads 0
  always_comb begin
    regRdData = '0;
    regRdData[MODE_W-1:0] = modeBits;
    regRdData[TEST_BIT] = 1'b0;
    regRdData[COL_LSB +: COL_W] = colCnt;
  end

  // R3: the tally never wraps from its top value
  p_no_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (colCnt == COL_MAX && !strobes.clrCol) |=> colCnt == COL_MAX);

  // R2: a host write leaves the tally alone
  p_tally_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.wrMode && !strobes.incCol && !strobes.clrCol) |=> $stable(colCnt));

endmodule

// File: rtl/txmode_reg.sv
module txmode_reg
  import txmode_pkg::*;
#(
  parameter int unsigned COL_W = 4,
  parameter int unsigned REM_W = 8,
  parameter int unsigned EARLY_GAP = 2,
  localparam int unsigned REG_W = COL_W + 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             regWrEn,
  input  logic [REG_W-1:0] regWrData,
  output logic [REG_W-1:0] regRdData,
  input  logic             colStrobe,
  input  logic             txDoneStrobe,
  input  logic             txActive,
  input  logic             linkFail,
  input  logic             jabber,
  input  logic             dmaStart,
  input  logic [REM_W-1:0] dmaRemain,
  output logic             dreq,
  output logic             loopbackEn,
  output logic             lineTxEn,
  output logic             carrierIgnore
);

  txCtlStrobes_t strobes;
  logic dreqReached;
  logic dreqArmed;
  logic dreqEarly;
  logic loopMode;

  txmode_ctrl #(.REM_W(REM_W), .EARLY_GAP(EARLY_GAP)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .regWrEn(regWrEn), .colStrobe(colStrobe),
    .txDoneStrobe(txDoneStrobe), .linkFail(linkFail), .jabber(jabber),
    .dmaStart(dmaStart), .dmaRemain(dmaRemain), .dreqEarly(dreqEarly),
    .loopMode(loopMode), .dreqArmed(dreqArmed), .dreqReached(dreqReached),
    .strobes(strobes)
  );

  txmode_datapath #(.COL_W(COL_W), .REG_W(REG_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .regWrData(regWrData),
    .txActive(txActive), .dreqReached(dreqReached), .regRdData(regRdData),
    .dreq(dreq), .dreqArmed(dreqArmed), .dreqEarly(dreqEarly),
    .loopMode(loopMode), .loopbackEn(loopbackEn), .lineTxEn(lineTxEn),
    .carrierIgnore(carrierIgnore)
  );

  // R4: frame end clears the tally by the next cycle
  p_tally_cleared_r4: assert property (@(posedge clk) disable iff (!rst_n)
    txDoneStrobe |=> regRdData[REG_W-1 -: COL_W] == '0);

  // R5: no request in the last cycle of a transfer
  p_last_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dmaRemain == '0) |-> !dreq);

  // R6: early mode drops the request EARLY_GAP cycles ahead
  p_early_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (regRdData[DREQEARLY_BIT] && dmaRemain <= REM_W'(EARLY_GAP)) |-> !dreq);

  // R7: forced loopback always blocks the line
  p_forced_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !regRdData[LOOPMODE_BIT] |-> (loopbackEn && !lineTxEn));

  // R8: standard loopback only while sending
  p_std_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (regRdData[LOOPMODE_BIT] && !txActive) |-> !loopbackEn);

  // R9: a collision during link failure or jabber drops loopback
  p_cancel_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (colStrobe && (linkFail || jabber) && regRdData[LOOPMODE_BIT]
     && !txDoneStrobe && !regWrEn) |=> !loopbackEn);

  // R10: carrier flag mirrors bit 0
  p_carrier_r10: assert property (@(posedge clk) disable iff (!rst_n)
    carrierIgnore == regRdData[CARRIER_BIT]);

endmodule

// File: tb/txmode_reg_tb.sv
module txmode_reg_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       regWrEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic       colStrobe = 1'b0;
  logic       txDoneStrobe = 1'b0;
  logic       txActive = 1'b0;
  logic       linkFail = 1'b0;
  logic       jabber = 1'b0;
  logic       dmaStart = 1'b0;
  logic [7:0] dmaRemain = 8'd10;
  logic       dreq;
  logic       loopbackEn;
  logic       lineTxEn;
  logic       carrierIgnore;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  txmode_reg u_dut (
    .clk(clk), .rst_n(rst_n), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .colStrobe(colStrobe), .txDoneStrobe(txDoneStrobe),
    .txActive(txActive), .linkFail(linkFail), .jabber(jabber),
    .dmaStart(dmaStart), .dmaRemain(dmaRemain), .dreq(dreq),
    .loopbackEn(loopbackEn), .lineTxEn(lineTxEn), .carrierIgnore(carrierIgnore)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Write on one negedge, release on the next; state is visible after #1
  task automatic hostWrite(input logic [7:0] d);
    @(negedge clk);
    regWrEn = 1'b1;
    regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
    #1;
  endtask

  task automatic pulseCol(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      colStrobe = 1'b1;
    end
    @(negedge clk);
    colStrobe = 1'b0;
    #1;
  endtask

  task automatic pulseDone(input logic withCol);
    @(negedge clk);
    txDoneStrobe = 1'b1;
    colStrobe = withCol;
    @(negedge clk);
    txDoneStrobe = 1'b0;
    colStrobe = 1'b0;
    #1;
  endtask

  task automatic startDma(input logic [7:0] rem);
    @(negedge clk);
    dmaStart = 1'b1;
    dmaRemain = rem;
    @(negedge clk);
    dmaStart = 1'b0;
    #1;
  endtask

  task automatic testReset();
    chk("R1 reset read", regRdData, 32'h06);
    chk("R1 reset dreq", dreq, 0);
    chk("R1 reset carrierIgnore", carrierIgnore, 0);
    chk("R8 idle loopback", loopbackEn, 0);
    chk("R8 line enabled", lineTxEn, 1);
  endtask

  task automatic testWrites();
    hostWrite(8'hFF);
    chk("R2 write ones, test bit and tally unchanged", regRdData, 32'h07);
    chk("R10 carrier ignore on", carrierIgnore, 1);
    hostWrite(8'h00);
    chk("R2 write zeros", regRdData, 32'h00);
    chk("R10 carrier ignore off", carrierIgnore, 0);
    hostWrite(8'h06);
    chk("R2 restore", regRdData, 32'h06);
  endtask

  task automatic testCollisions();
    pulseCol(3);
    chk("R3 three collisions", regRdData, 32'h36);
    hostWrite(8'hF6);
    chk("R2 tally read-only", regRdData, 32'h36);
    pulseCol(14);
    chk("R3 saturate at 15", regRdData, 32'hF6);
    pulseDone(1'b1);
    chk("R4 clear wins over collision", regRdData, 32'h06);
    pulseCol(1);
    chk("R3 count after clear", regRdData, 32'h16);
    pulseDone(1'b0);
    chk("R4 plain clear", regRdData, 32'h06);
  endtask

  task automatic testDreqNormal();
    hostWrite(8'h02);
    startDma(8'd5);
    chk("R5 armed after start", dreq, 1);
    dmaRemain = 8'd1; #1;
    chk("R5 high one before last", dreq, 1);
    dmaRemain = 8'd0; #1;
    chk("R5 low in last cycle", dreq, 0);
    @(negedge clk);
    dmaRemain = 8'd4; #1;
    chk("R5 stays low until start", dreq, 0);
    startDma(8'd4);
    chk("R5 re-armed", dreq, 1);
    dmaRemain = 8'd0;
    @(negedge clk);
  endtask

  task automatic testDreqEarly();
    hostWrite(8'h06);
    startDma(8'd5);
    chk("R6 armed after start", dreq, 1);
    dmaRemain = 8'd3; #1;
    chk("R6 high at three", dreq, 1);
    dmaRemain = 8'd2; #1;
    chk("R6 low at two", dreq, 0);
    @(negedge clk);
    dmaRemain = 8'd3; #1;
    chk("R6 stays low until start", dreq, 0);
  endtask

  task automatic testForced();
    hostWrite(8'h00);
    txActive = 1'b1;
    linkFail = 1'b1;
    pulseCol(1);
    chk("R7 forced loopback survives collision", loopbackEn, 1);
    chk("R7 line blocked", lineTxEn, 0);
    txActive = 1'b0; #1;
    chk("R7 forced loopback when idle", loopbackEn, 1);
    linkFail = 1'b0;
    pulseDone(1'b0);
  endtask

  task automatic testStandard();
    hostWrite(8'h02);
    chk("R8 idle standard loopback off", loopbackEn, 0);
    txActive = 1'b1; #1;
    chk("R8 standard loopback while sending", loopbackEn, 1);
    chk("R8 line enabled", lineTxEn, 1);
    pulseCol(1);
    chk("R9 plain collision keeps loopback", loopbackEn, 1);
    jabber = 1'b1;
    pulseCol(1);
    jabber = 1'b0; #1;
    chk("R9 jabber collision cancels", loopbackEn, 0);
    pulseDone(1'b0);
    chk("R9 cancel lifted after frame", loopbackEn, 1);
    txActive = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    testReset();
    testWrites();
    testCollisions();
    testDreqNormal();
    testDreqEarly();
    testForced();
    testStandard();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule